// File: doc/BRIEF.md
# USB Frame Interval Timer

This block produces the full-speed frame timing for a USB host controller. It keeps a programmable frame interval and counts down the bit times left in the current frame. When the countdown is at zero and another bit time passes, the block reloads the countdown from the interval and advances a 16-bit frame number. It also issues a one-cycle start-of-frame strobe, plus a second strobe whenever the most significant bit of the frame number changes.

Software uses three 32-bit registers, chosen by a two-bit select:

- **Interval word:** the frame interval, a largest-data-packet field and an update toggle.
- **Frame word:** a read-only view of the frame number, the remaining count and a mirrored toggle.
- **Threshold word:** the low-speed threshold.

Software inverts the interval toggle each time it writes a new interval. The mirrored toggle copies it at the next reload, so software can see when the new interval has taken effect. The counters advance only while a run-enable input is high, on cycles that carry a bit-time enable.

Top module: `usb_frame_timer`

## Requirements
- R1: After a synchronous reset the registers read as follows:
  - select 0 (interval word) reads 0x2778_2EDF (interval 0x2EDF, packet field 0x2778 = 6*(0x2EDF-210)/7, toggle 0).
  - select 1 (frame word) reads 0x2EDF_0000.
  - select 2 (threshold word) reads 0x0000_0628.
  - Both strobes are low.
- R2: The remaining count (frame word bits [29:16]) decreases by exactly one on each clock where run_en and bit_tick are both high and the count is non-zero.
- R3: On a clock where run_en and bit_tick are high and the remaining count is zero, the following happen together, so a frame spans interval+1 bit ticks:
  - the remaining count reloads from the interval field;
  - the frame number (frame word bits [15:0]) increments modulo 2^16;
  - sof_pulse is high for exactly the next cycle.
- R4: The remaining toggle (frame word bit 31) takes the value of the interval toggle (interval word bit 31) at each reload and holds between reloads.
- R5: ovf_pulse is high for one cycle, together with sof_pulse, when frame-number bit 15 changes. This happens when the frame number goes 0x7FFF to 0x8000 and 0xFFFF to 0x0000, and at no other time.
- R6: While run_en is low, or bit_tick is low, the frame number and remaining count hold; with run_en low since reset the frame number stays 0.
- R7: A write with select 0 stores:
  - bits [13:0] as the interval;
  - bits [30:16] as the packet field;
  - bit 31 as the toggle.

  Bits [15:14] read as zero. The new interval is used only at the next reload and does not alter the countdown in progress.
- R8: Writes with select 1 have no effect on the frame number, remaining count or remaining toggle.
- R9: A write with select 2 stores bits [11:0] as the low-speed threshold; bits [31:12] read as zero.
- R10: rd_data shows the word picked by rd_sel combinationally; select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counters advance only while high |
| bit_tick | input | 1 | One-cycle enable per full-speed bit time |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 interval, 1 frame (ignored), 2 threshold |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding, 3 reads zero |
| rd_data | output | 32 | Selected register word |
| sof_pulse | output | 1 | Start-of-frame strobe |
| ovf_pulse | output | 1 | Frame-number bit-15 change strobe |
| frame_num | output | 16 | Current frame number |
| frame_remain | output | 14 | Bit times left in the frame |

## Verification
The properties take run_en and bit_tick to be ordinary synchronous levels, and take the remaining count to be non-zero whenever it is decremented. The bench drives every input one time unit after the rising edge, so each value is stable across the next edge. It writes the interval only while run_en is low, so a write never coincides with a reload. Shrinking the interval to zero makes every bit tick a frame, which brings both frame-number transitions of bit 15 within reach of the run.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int REG_W    = 32;
    localparam int FI_W     = 14;
    localparam int FN_W     = 16;
    localparam int LDP_W    = 15;
    localparam int LST_W    = 12;
    localparam int LDP_LSB  = 16;
    localparam int REM_LSB  = 16;
    localparam int TOG_BIT  = 31;

    // Writable bits of the interval word: interval, packet field, toggle
    localparam logic [REG_W-1:0] INT_MASK =
        (32'(1) << TOG_BIT) | ((32'(1) << (LDP_LSB + LDP_W)) - (32'(1) << LDP_LSB)) |
        ((32'(1) << FI_W) - 32'(1));
    localparam logic [REG_W-1:0] LST_MASK = (32'(1) << LST_W) - 32'(1);

    typedef enum logic [1:0] {
        SEL_INTERVAL = 2'd0,
        SEL_FRAME    = 2'd1,
        SEL_LSTHR    = 2'd2,
        SEL_NONE     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            frt;
        logic [FN_W-1:0] fn;
        logic [FI_W-1:0] rem;
    } frame_state_t;

    function automatic logic [LDP_W-1:0] ldp_default(input logic [FI_W-1:0] fi);
        logic [31:0] v;
        v = (32'd6 * (32'(fi) - 32'd210)) / 32'd7;
        return v[LDP_W-1:0];
    endfunction

    function automatic logic [REG_W-1:0] interval_reset_word(input logic [FI_W-1:0] fi);
        return (32'(ldp_default(fi)) << LDP_LSB) | 32'(fi);
    endfunction

    function automatic logic [REG_W-1:0] frame_word(input frame_state_t s);
        return (32'(s.frt) << TOG_BIT) | (32'(s.rem) << REM_LSB) | 32'(s.fn);
    endfunction

endpackage

// File: rtl/uft_cfg_regs.sv
module uft_cfg_regs
    import uft_pkg::*;
#(
    parameter logic [FI_W-1:0]  FI_RESET  = 14'h2EDF,
    parameter logic [LST_W-1:0] LST_RESET = 12'h628
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] interval_q,
    output logic [REG_W-1:0] lsthr_q
);
    localparam logic [REG_W-1:0] INT_RST = interval_reset_word(FI_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            interval_q <= INT_RST;
            lsthr_q    <= 32'(LST_RESET);
        end else if (wr_en) begin
            case (wr_sel)
                SEL_INTERVAL: interval_q <= wr_data & INT_MASK;
                SEL_LSTHR:    lsthr_q    <= wr_data & LST_MASK;
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/uft_frame_counter.sv
module uft_frame_counter
    import uft_pkg::*;
#(
    parameter logic [FI_W-1:0] FI_RESET = 14'h2EDF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic [FI_W-1:0] reload_fi,
    input  logic            reload_tog,
    output frame_state_t    state,
    output logic            sof,
    output logic            ovf
);
    logic [FN_W-1:0] fn_next;
    logic            at_end;

    assign fn_next = state.fn + 1'b1;
    assign at_end  = (state.rem == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state.frt <= 1'b0;
            state.fn  <= '0;
            state.rem <= FI_RESET;
            sof       <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            sof <= 1'b0;
            ovf <= 1'b0;
            if (advance) begin
                if (at_end) begin
                    state.rem <= reload_fi;
                    state.fn  <= fn_next;
                    state.frt <= reload_tog;
                    sof       <= 1'b1;
                    ovf       <= fn_next[FN_W-1] ^ state.fn[FN_W-1];
                end else begin
                    state.rem <= state.rem - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uft_read_mux.sv
module uft_read_mux
    import uft_pkg::*;
(
    input  reg_sel_e         rd_sel,
    input  logic [REG_W-1:0] interval_q,
    input  logic [REG_W-1:0] lsthr_q,
    input  frame_state_t     state,
    output logic [REG_W-1:0] rd_data
);
    always_comb begin
        case (rd_sel)
            SEL_INTERVAL: rd_data = interval_q;
            SEL_FRAME:    rd_data = frame_word(state);
            SEL_LSTHR:    rd_data = lsthr_q;
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import uft_pkg::*;
#(
    parameter logic [FI_W-1:0]  FI_RESET  = 14'h2EDF,
    parameter logic [LST_W-1:0] LST_RESET = 12'h628
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run_en,
    input  logic        bit_tick,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        sof_pulse,
    output logic        ovf_pulse,
    output logic [15:0] frame_num,
    output logic [13:0] frame_remain
);
    logic [REG_W-1:0] interval_q;
    logic [REG_W-1:0] lsthr_q;
    frame_state_t     fstate;
    logic             int_toggle;
    logic             rem_toggle;

    uft_cfg_regs #(.FI_RESET(FI_RESET), .LST_RESET(LST_RESET)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (reg_sel_e'(wr_sel)),
        .wr_data    (wr_data),
        .interval_q (interval_q),
        .lsthr_q    (lsthr_q)
    );

    assign int_toggle = interval_q[TOG_BIT];

    uft_frame_counter #(.FI_RESET(FI_RESET)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .advance    (run_en & bit_tick),
        .reload_fi  (interval_q[FI_W-1:0]),
        .reload_tog (int_toggle),
        .state      (fstate),
        .sof        (sof_pulse),
        .ovf        (ovf_pulse)
    );

    uft_read_mux u_rd (
        .rd_sel     (reg_sel_e'(rd_sel)),
        .interval_q (interval_q),
        .lsthr_q    (lsthr_q),
        .state      (fstate),
        .rd_data    (rd_data)
    );

    assign rem_toggle   = fstate.frt;
    assign frame_num    = fstate.fn;
    assign frame_remain = fstate.rem;
endmodule

// File: rtl/uft_checker.sv
module uft_checker (
    input logic        clk,
    input logic        rst,
    input logic        run_en,
    input logic        bit_tick,
    input logic        sof_pulse,
    input logic        ovf_pulse,
    input logic [15:0] frame_num,
    input logic [13:0] frame_remain,
    input logic        int_toggle,
    input logic        rem_toggle
);
    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        (run_en && bit_tick && frame_remain != 14'd0) |=>
            (frame_remain == $past(frame_remain) - 14'd1) && !sof_pulse);

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (run_en && bit_tick && frame_remain == 14'd0) |=>
            sof_pulse && (frame_num == 16'($past(frame_num) + 16'd1)));

    p_toggle_copy_r4: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> (rem_toggle == $past(int_toggle)));

    p_toggle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(run_en && bit_tick) |=> $stable(rem_toggle));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> sof_pulse && (frame_num[15] != $past(frame_num[15])));

    p_overflow_seen_r5: assert property (@(posedge clk) disable iff (rst)
        (sof_pulse && frame_num[14:0] == 15'd0) |-> ovf_pulse);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(run_en && bit_tick) |=> $stable(frame_num) && $stable(frame_remain) && !sof_pulse);
endmodule

bind usb_frame_timer uft_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .run_en       (run_en),
    .bit_tick     (bit_tick),
    .sof_pulse    (sof_pulse),
    .ovf_pulse    (ovf_pulse),
    .frame_num    (frame_num),
    .frame_remain (frame_remain),
    .int_toggle   (int_toggle),
    .rem_toggle   (rem_toggle)
);

// File: tb/usb_frame_timer_tb.sv
`timescale 1ns/100ps
module usb_frame_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        sof_pulse, ovf_pulse;
    logic [15:0] frame_num;
    logic [13:0] frame_remain;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit armed = 0;
    bit done = 0;

    // reference model state
    int m_fi, m_ldp, m_fit, m_lst, m_rem, m_fn, m_frt, m_sof, m_ovf;

    always #2.5 clk = ~clk;

    usb_frame_timer u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .sof_pulse(sof_pulse), .ovf_pulse(ovf_pulse),
        .frame_num(frame_num), .frame_remain(frame_remain)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int model_word(input int sel);
        case (sel)
            0: return (m_fit << 31) | (m_ldp << 16) | m_fi;
            1: return (m_frt << 31) | (m_rem << 16) | m_fn;
            2: return m_lst;
            default: return 0;
        endcase
    endfunction

    // behavioural model updated at each rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_fi = 'h2EDF; m_ldp = (6 * ('h2EDF - 210)) / 7; m_fit = 0;
            m_lst = 'h628; m_rem = 'h2EDF; m_fn = 0; m_frt = 0;
            m_sof = 0; m_ovf = 0;
            armed = 1;
        end else begin
            m_sof = 0; m_ovf = 0;
            if (run_en && bit_tick) begin
                if (m_rem == 0) begin
                    int nfn;
                    nfn = (m_fn + 1) & 'hFFFF;
                    m_ovf = ((nfn >> 15) != (m_fn >> 15)) ? 1 : 0;
                    m_sof = 1;
                    m_fn = nfn;
                    m_rem = m_fi;
                    m_frt = m_fit;
                end else begin
                    m_rem = m_rem - 1;
                end
            end
            if (wr_en) begin
                if (wr_sel == 2'd0) begin
                    m_fi = wr_data & 'h3FFF;
                    m_ldp = (wr_data >> 16) & 'h7FFF;
                    m_fit = wr_data[31];
                end else if (wr_sel == 2'd2) begin
                    m_lst = wr_data & 'hFFF;
                end
            end
        end
        if (cyc > 200000 && !done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=<200000 cycles", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            chk("R3 sof_pulse", 32'(sof_pulse), 32'(m_sof));
            chk("R5 ovf_pulse", 32'(ovf_pulse), 32'(m_ovf));
            chk("R3 frame_num", 32'(frame_num), 32'(m_fn));
            chk("R2 frame_remain", 32'(frame_remain), 32'(m_rem));
            chk("R10 rd_data", rd_data, 32'(model_word(int'(rd_sel))));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] d);
        run_en = 1'b0; wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        rd_sel = sel;
        #0.5;
        chk(req, rd_data, exp);
    endtask

    initial begin
        int n;
        int ovf_cnt;
        logic [15:0] ovf_fn [2];
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        read_chk("R1 interval word", 2'd0, 32'h2778_2EDF);
        read_chk("R1 frame word", 2'd1, 32'h2EDF_0000);
        read_chk("R1 threshold word", 2'd2, 32'h0000_0628);
        read_chk("R10 select 3 zero", 2'd3, 32'h0);
        chk("R1 sof low", 32'(sof_pulse), 32'd0);

        // R6 hold while run_en low
        run_en = 1'b0; bit_tick = 1'b1;
        repeat (20) step();
        chk("R6 frame_num held at zero", 32'(frame_num), 32'd0);
        chk("R6 remaining held", 32'(frame_remain), 32'h2EDF);

        // R2 decrement on five of ten cycles
        run_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            bit_tick = (i % 2 == 0);
            step();
        end
        bit_tick = 1'b0;
        chk("R2 five ticks", 32'(frame_remain), 32'h2EDA);
        repeat (3) step();
        chk("R6 tick low holds", 32'(frame_remain), 32'h2EDA);

        // R7 interval write, reserved bits dropped, countdown untouched
        write_reg(2'd0, 32'h9234_C005);
        read_chk("R7 interval readback", 2'd0, 32'h9234_0005);
        chk("R7 countdown unchanged", 32'(frame_remain), 32'h2EDA);
        read_chk("R4 toggle before reload", 2'd1, 32'h2EDA_0000);

        // R3/R4 reach reload
        run_en = 1'b1; bit_tick = 1'b1;
        n = 0;
        while (!sof_pulse && n < 20000) begin step(); n++; end
        chk("R3 ticks to first reload", 32'(n), 32'h2EDB);
        chk("R3 frame_num after reload", 32'(frame_num), 32'd1);
        chk("R3 reload value", 32'(frame_remain), 32'd5);
        read_chk("R4 toggle mirrored", 2'd1, 32'h8005_0001);

        // R3 frame length interval+1
        n = 0;
        do begin step(); n++; end while (!sof_pulse && n < 100);
        chk("R3 frame length", 32'(n), 32'd6);
        chk("R3 frame_num second", 32'(frame_num), 32'd2);

        // R8 frame word writes ignored
        write_reg(2'd1, 32'hFFFF_FFFF);
        read_chk("R8 frame word untouched", 2'd1, 32'h8005_0002);

        // R9 threshold write
        write_reg(2'd2, 32'hFFFF_FABC);
        read_chk("R9 threshold readback", 2'd2, 32'h0000_0ABC);

        // R5 overflow: one-tick frames until the frame number wraps
        write_reg(2'd0, 32'h0000_0000);
        run_en = 1'b1; bit_tick = 1'b1;
        ovf_cnt = 0;
        for (int i = 0; i < 65600; i++) begin
            rd_sel = 2'(i);
            step();
            if (ovf_pulse) begin
                if (ovf_cnt < 2) ovf_fn[ovf_cnt] = frame_num;
                ovf_cnt++;
            end
        end
        chk("R5 overflow count", 32'(ovf_cnt), 32'd2);
        chk("R5 first overflow at 0x8000", 32'(ovf_fn[0]), 32'h8000);
        chk("R5 second overflow at wrap", 32'(ovf_fn[1]), 32'h0000);
        read_chk("R4 toggle cleared", 2'd1, (32'(frame_remain) << 16) | 32'(frame_num));

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule